// File: doc/BRIEF.md
# Framed Byte-Stream Register Bridge

This block sits between a processor's load/store bus and a byte-wide packet port, such as the client side of an Ethernet MAC. It provides four word registers: receive status, receive data, transmit status and transmit data. Software polls a status register, then moves one byte per access through a data register. Each data word carries the byte together with two marker bits. One marker flags the first byte of a packet and the other flags the last byte, so a packet boundary never costs an extra bus access or an extra stream cycle.

Each direction has a one-entry holding register. On the receive side, an incoming byte is captured when the stream handshake completes. It stays held until software reads it, and further bytes are refused until then. On the transmit side, a write fills the holding register. The block then presents that byte on the outgoing stream until the consumer takes it.

Top module: `framed_stream_bridge`

## Requirements
- R1: Only the four word-aligned addresses BASE+0x0 (receive status), BASE+0x4 (receive data), BASE+0x8 (transmit status) and BASE+0xC (transmit data) select the block. The default BASE is 0xFFFF0010. A read of any other address returns zero, and a write to any other address has no effect.
- R2: `bus_rdata` is registered. It shows the read result in the cycle after `bus_rd` is sampled high, and it is zero after any cycle without a read.
- R3: A receive status read returns bit 0 = 1 while a received byte is held. All other bits read 0.
- R4: A received byte is captured only in a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low while a byte is held.
- R5: A receive data read returns the held byte in bits 7:0, its start marker in bit 8 and its end marker in bit 9, with bits 31:10 zero. The read releases the slot, so `rx_ready` is high in the next cycle. A receive data read with nothing held returns zero.
- R6: A transmit status read returns bit 0 = 1 when the transmit holding register is empty. All other bits read 0.
- R7: A transmit data write to an empty holding register drives `tx_byte` from bits 7:0, `tx_sof` from bit 8 and `tx_eof` from bit 9 of the written word, starting in the next cycle. `tx_valid` stays high and these outputs stay stable until `tx_ready` is seen high.
- R8: A transmit data write while `tx_valid` is high is ignored.
- R9: A cycle with `tx_valid` and `tx_ready` both high empties the holding register, so `tx_valid` is low in the next cycle unless a new write follows.
- R10: A read of the transmit data register returns zero. Writes to the two status registers and to the receive data register have no effect.
- R11: Synchronous reset empties both holding registers, so `tx_valid` is low and `rx_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_byte | output | 8 | Outgoing byte |
| tx_sof | output | 1 | Outgoing first-byte marker |
| tx_eof | output | 1 | Outgoing last-byte marker |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Consumer accepts outgoing byte |
| rx_byte | input | 8 | Incoming byte |
| rx_sof | input | 1 | Incoming first-byte marker |
| rx_eof | input | 1 | Incoming last-byte marker |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Block accepts incoming byte |

## Verification
The properties assume a bus that raises at most one of `bus_rd` and `bus_wr` in a cycle. They also assume that the transmit consumer may raise `tx_ready` in any cycle and that the receive producer may change its byte while `rx_ready` is low. The stimulus never raises both strobes together. It draws `tx_ready`, `rx_valid` and the incoming byte freely each cycle. Its addresses mix the four registers with an out-of-range address and a misaligned one.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int BYTE_W  = 8;
  localparam int SOF_BIT = BYTE_W;
  localparam int EOF_BIT = BYTE_W + 1;
  localparam int WORD_W  = BYTE_W + 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_STAT,
    SEL_RX_DATA,
    SEL_TX_STAT,
    SEL_TX_DATA
  } sel_e;

  typedef struct packed {
    logic              eof;
    logic              sof;
    logic [BYTE_W-1:0] data;
  } fbyte_t;
endpackage

// File: rtl/fsb_decode.sv
module fsb_decode
  import fsb_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0010
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  logic hit;

  assign hit = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (hit) begin
      case (addr[3:2])
        2'd0:    sel = SEL_RX_STAT;
        2'd1:    sel = SEL_RX_DATA;
        2'd2:    sel = SEL_TX_STAT;
        default: sel = SEL_TX_DATA;
      endcase
    end
  end
endmodule

// File: rtl/fsb_slot.sv
module fsb_slot
  import fsb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   push,
  input  logic   pop,
  input  fbyte_t din,
  output logic   full,
  output fbyte_t dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      dout <= '0;
    end else if (full) begin
      if (pop) full <= 1'b0;
    end else if (push) begin
      full <= 1'b1;
      dout <= din;
    end
  end
endmodule

// File: rtl/framed_stream_bridge.sv
module framed_stream_bridge
  import fsb_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter int                DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_valid,
  output logic              rx_ready
);
  localparam int PAD_W = DATA_W - WORD_W;

  sel_e   sel;
  logic   rx_full, tx_full;
  fbyte_t rx_held, tx_held, rx_in, tx_in;
  logic   rx_push, rx_pop, tx_push, tx_pop;
  logic   wdata_unused;

  assign wdata_unused = &{1'b0, bus_wdata[DATA_W-1:WORD_W]};

  fsb_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign rx_in   = '{eof: rx_eof, sof: rx_sof, data: rx_byte};
  assign rx_push = rx_valid && !rx_full;
  assign rx_pop  = bus_rd && (sel == SEL_RX_DATA);

  fsb_slot u_rx (
    .clk  (clk),
    .rst  (rst),
    .push (rx_push),
    .pop  (rx_pop),
    .din  (rx_in),
    .full (rx_full),
    .dout (rx_held)
  );

  assign tx_in   = fbyte_t'(bus_wdata[WORD_W-1:0]);
  assign tx_push = bus_wr && (sel == SEL_TX_DATA);
  assign tx_pop  = tx_ready;

  fsb_slot u_tx (
    .clk  (clk),
    .rst  (rst),
    .push (tx_push),
    .pop  (tx_pop),
    .din  (tx_in),
    .full (tx_full),
    .dout (tx_held)
  );

  assign rx_ready = !rx_full;
  assign tx_valid = tx_full;
  assign tx_byte  = tx_held.data;
  assign tx_sof   = tx_held.sof;
  assign tx_eof   = tx_held.eof;

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (sel)
        SEL_RX_STAT: bus_rdata <= {{(DATA_W-1){1'b0}}, rx_full};
        SEL_RX_DATA: bus_rdata <= rx_full ? {{PAD_W{1'b0}}, rx_held} : '0;
        SEL_TX_STAT: bus_rdata <= {{(DATA_W-1){1'b0}}, !tx_full};
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int                ADDR_W = 32,
  parameter int                DATA_W = 32,
  parameter int                BYTE_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0010
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              tx_sof,
  input logic              tx_eof,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready
);
  localparam logic [ADDR_W-1:0] A_RXD = BASE + 4;
  localparam logic [ADDR_W-1:0] A_TXD = BASE + 12;

  p_reset_state_r11: assert property (@(posedge clk) rst |=> (!tx_valid && rx_ready));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:BYTE_W+2] == '0);

  p_rx_block_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready) |=> !rx_ready);

  p_rx_release_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_RXD && !rx_ready) |=> rx_ready);

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_sof) && $stable(tx_eof)));

  p_tx_drain_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_valid);

  p_tx_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid && !(bus_wr && bus_addr == A_TXD)) |=> !tx_valid);
endmodule

bind framed_stream_bridge fsb_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BYTE_W (fsb_pkg::BYTE_W),
  .BASE   (BASE)
) u_fsb_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .tx_byte   (tx_byte),
  .tx_sof    (tx_sof),
  .tx_eof    (tx_eof),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready)
);

// File: tb/test_framed_stream_bridge.sv
module test_framed_stream_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_RXC = 32'hFFFF_0010;
  localparam logic [31:0] A_RXD = 32'hFFFF_0014;
  localparam logic [31:0] A_TXC = 32'hFFFF_0018;
  localparam logic [31:0] A_TXD = 32'hFFFF_001C;
  localparam logic [31:0] A_OUT = 32'hFFFF_0020;
  localparam logic [31:0] A_MIS = 32'hFFFF_0016;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] tx_byte, rx_byte = '0;
  logic tx_sof, tx_eof, tx_valid, tx_ready = 1'b0;
  logic rx_sof = 1'b0, rx_eof = 1'b0, rx_valid = 1'b0, rx_ready;

  int checks = 0;
  int fails = 0;

  logic       m_rx_full = 1'b0, m_tx_full = 1'b0;
  logic [9:0] m_rx_word = '0, m_tx_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  framed_stream_bridge i_framed_stream_bridge (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_byte(tx_byte), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_byte(rx_byte),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] a);
    case (a)
      A_RXC:   return {31'b0, m_rx_full};
      A_RXD:   return m_rx_full ? {22'b0, m_rx_word} : 32'b0;
      A_TXC:   return {31'b0, !m_tx_full};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string read_tag(input logic rd, input logic [31:0] a);
    if (!rd) return "R2";
    case (a)
      A_RXC:   return "R3";
      A_RXD:   return "R5";
      A_TXC:   return "R6";
      A_TXD:   return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [31:0] a, input logic [31:0] wd,
                      input logic rxv, input logic [9:0] rxw, input logic txr);
    logic [31:0] e_rd;
    string tag;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rxv; rx_byte = rxw[7:0]; rx_sof = rxw[8]; rx_eof = rxw[9];
    tx_ready = txr;
    e_rd = rd ? exp_read(a) : 32'b0;
    tag = read_tag(rd, a);
    if (rd && a == A_RXD && m_rx_full) m_rx_full = 1'b0;
    else if (rxv && !m_rx_full) begin m_rx_full = 1'b1; m_rx_word = rxw; end
    if (m_tx_full) begin if (txr) m_tx_full = 1'b0; end
    else if (wr && a == A_TXD) begin m_tx_full = 1'b1; m_tx_word = wd[9:0]; end
    @(posedge clk);
    #1;
    chk(tag, bus_rdata, e_rd);
    chk("R7 tx_valid", {31'b0, tx_valid}, {31'b0, m_tx_full});
    if (m_tx_full) chk("R7 tx word", {22'b0, tx_eof, tx_sof, tx_byte}, {22'b0, m_tx_word});
    chk("R4 rx_ready", {31'b0, rx_ready}, {31'b0, !m_rx_full});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R11 tx_valid", {31'b0, tx_valid}, 32'd0);
    chk("R11 rx_ready", {31'b0, rx_ready}, 32'd1);
    chk("R11 rdata", bus_rdata, 32'd0);

    step(1, 0, A_TXC, 0, 0, 0, 0);
    step(1, 0, A_RXC, 0, 0, 0, 0);
    step(1, 0, A_RXD, 0, 0, 0, 0);
    // transmit frame: start byte held, busy write ignored, then drained
    step(0, 1, A_TXD, 32'h0000_01A5, 0, 0, 0);
    step(0, 1, A_TXD, 32'h0000_02FF, 0, 0, 0);
    chk("R8 byte kept", {24'b0, tx_byte}, 32'hA5);
    chk("R8 flags kept", {30'b0, tx_eof, tx_sof}, 32'd1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R9 drained", {31'b0, tx_valid}, 32'd0);
    step(0, 1, A_TXD, 32'hFFFF_FE3C, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    // receive: single-byte frame, second byte refused while held
    step(0, 0, 0, 0, 1, 10'h37E, 0);
    step(1, 0, A_RXC, 0, 1, 10'h111, 0);
    step(1, 0, A_RXD, 0, 1, 10'h122, 0);
    step(1, 0, A_RXD, 0, 0, 0, 0);
    step(1, 0, A_RXD, 0, 0, 0, 0);
    // no-effect accesses
    step(0, 1, A_RXC, 32'h3FF, 0, 0, 0);
    step(0, 1, A_TXC, 32'h3FF, 0, 0, 0);
    step(0, 1, A_RXD, 32'h3FF, 0, 0, 0);
    step(0, 1, A_OUT, 32'h3FF, 0, 0, 0);
    step(0, 1, A_MIS, 32'h3FF, 0, 0, 0);
    chk("R10 no tx", {31'b0, tx_valid}, 32'd0);
    step(1, 0, A_TXD, 0, 0, 0, 0);
    step(1, 0, A_OUT, 0, 0, 0, 0);
    step(1, 0, A_MIS, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] op;
      logic [31:0] a;
      op = 3'($urandom_range(0, 4));
      case ($urandom_range(0, 5))
        0: a = A_RXC; 1: a = A_RXD; 2: a = A_TXC; 3: a = A_TXD; 4: a = A_OUT; default: a = A_MIS;
      endcase
      if (op == 3'd1 && $urandom_range(0, 1) == 1) a = A_TXD;
      step(op == 3'd0 || op == 3'd2, op == 3'd1, a, $urandom, 1'($urandom_range(0, 1)),
           10'($urandom), 1'($urandom_range(0, 2) == 0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule